// File: doc/BRIEF.md
# Strip Frame Hit Extractor

This block sits behind the digitiser of a silicon strip readout chain. It takes a stream of frames, each made of one header word and then one sample per strip in strip order. It checks the header against a programmable pattern and subtracts a stored pedestal from every sample. It then removes the offset that all strips of the frame share and reports only the groups of adjacent strips that stand above a threshold. Each group leaves the block as one short record, so far less data goes out than comes in.

A frame is held in an internal buffer while the shared offset is gathered. After the last sample arrives, the buffer is scanned once, one strip per clock. The records come out during that scan, and a one-cycle end-of-frame pulse follows the scan. Pedestals, the threshold and the header pattern are loaded through a small address/data/write-enable port. That port only takes effect while the block is waiting for a header.

Top module: `strip_hit_extractor`

## Requirements
- R1: A frame is one header word followed by NSTRIP (default 128) samples of DW (default 10) bits, taken in strip order 0 to NSTRIP-1, one per cycle in which in_valid is high. A word counts as a header only if it equals the programmed header pattern.
- R2: A valid word that arrives while the block waits for a header and does not match the pattern raises sync_err for exactly one cycle, in the cycle after the word. The word is dropped and the block keeps waiting, so every further non-matching word is flagged the same way until a matching word arrives.
- R3: The stored pedestal of strip i is subtracted from sample i, as signed arithmetic with no clipping.
- R4: The common-mode level is the mean of the NSTRIP pedestal-corrected samples, rounded toward minus infinity. It is subtracted from every corrected sample of the same frame.
- R5: A strip is hit when its fully corrected value is strictly greater than the unsigned threshold. A value equal to the threshold is not a hit.
- R6: Every maximal run of adjacent hit strips produces exactly one record: clu_first holds the lowest strip index, clu_size the number of strips and clu_charge the signed sum of their corrected values. Records appear in increasing strip order, each for one cycle on clu_valid, and a run that reaches strip NSTRIP-1 is reported as well.
- R7: frame_end is high for exactly one cycle per accepted frame. It comes after the last record of that frame, and clu_valid is low in that cycle.
- R8: Configuration writes (cfg_we high) use these addresses: 0 to NSTRIP-1 set the pedestal of that strip, NSTRIP sets the threshold and NSTRIP+1 sets the header pattern. A write takes effect only while the block waits for a header; at any other time it has no effect.
- R9: Valid words that arrive after the last sample of a frame and before its frame_end pulse are ignored. They neither start a frame nor raise sync_err.
- R10: During and right after reset, clu_valid, frame_end and sync_err are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Qualifies in_data in this cycle |
| in_data | input | DW | Header or sample word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | clog2(NSTRIP+2) | Configuration address (pedestal, threshold, pattern) |
| cfg_data | input | DW | Configuration write data |
| clu_valid | output | 1 | Cluster record present this cycle |
| clu_first | output | clog2(NSTRIP) | Lowest strip index of the cluster |
| clu_size | output | clog2(NSTRIP)+1 | Number of strips in the cluster |
| clu_charge | output | DW+3+clog2(NSTRIP) | Signed sum of corrected values |
| frame_end | output | 1 | One-cycle pulse closing a frame |
| sync_err | output | 1 | One-cycle pulse for a rejected header word |

## Verification
On every cycle, assertions check the following:
- Each record is non-empty, stays inside the frame and carries at least size times (threshold+1) of charge.
- Two records in consecutive cycles only happen when the second one sits on the last strip.
- frame_end is a single-cycle pulse that never overlaps a record.
- sync_err always follows a valid word.
- The threshold never changes while a frame is in progress.

Only the bench's scenarios can show the arithmetic behaviour: the pedestal values per strip, floor rounding of a negative common mode, and the strict threshold comparison. The same holds for resynchronisation after bad headers and for the words and configuration writes that are ignored during a scan, which the bench observes through the records of the frames that follow.

// File: rtl/sfhe_pkg.sv
package sfhe_pkg;
   typedef enum logic [1:0] {
      ST_HDR  = 2'd0,
      ST_SMP  = 2'd1,
      ST_SCAN = 2'd2,
      ST_DONE = 2'd3
   } sfhe_state_e;
endpackage

// File: rtl/sfhe_cfg_store.sv
module sfhe_cfg_store #(
   parameter int NSTRIP  = 128,
   parameter int DW      = 10,
   parameter int THR_RST = 32,
   parameter int HDR_RST = 'h3A5,
   localparam int LOG2N  = $clog2(NSTRIP),
   localparam int AW     = $clog2(NSTRIP + 2)
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idle,
   input  logic             wr_req,
   input  logic [AW-1:0]    wr_addr,
   input  logic [DW-1:0]    wr_data,
   input  logic [LOG2N-1:0] rd_idx,
   output logic [DW-1:0]    ped,
   output logic [DW-1:0]    thr,
   output logic [DW-1:0]    hdr_pat
);
   logic [DW-1:0] ped_mem [NSTRIP];
   logic          wr_ok;

   assign wr_ok = wr_req && idle;

   always_ff @(posedge clk) begin
      if (wr_ok && (wr_addr < AW'(NSTRIP)))
         ped_mem[wr_addr[LOG2N-1:0]] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         thr     <= DW'(THR_RST);
         hdr_pat <= DW'(HDR_RST);
      end else if (wr_ok) begin
         if (wr_addr == AW'(NSTRIP))     thr     <= wr_data;
         if (wr_addr == AW'(NSTRIP + 1)) hdr_pat <= wr_data;
      end
   end

   assign ped = ped_mem[rd_idx];

   // R8: threshold is frozen while a frame is in progress
   assert_thr_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !idle |=> $stable(thr));
endmodule

// File: rtl/sfhe_frame_buf.sv
module sfhe_frame_buf #(
   parameter int NSTRIP  = 128,
   parameter int DW      = 10,
   parameter int CM_MODE = 1,
   localparam int LOG2N  = $clog2(NSTRIP),
   localparam int VW     = DW + 3,
   localparam int QW     = VW + LOG2N
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 wr,
   input  logic [LOG2N-1:0]     idx,
   input  logic [DW-1:0]        sample,
   input  logic [DW-1:0]        ped,
   output logic signed [VW-1:0] rd_val
);
   logic signed [VW-1:0] mem [NSTRIP];
   logic signed [VW-1:0] corr;
   logic signed [VW-1:0] mean;
   logic signed [QW-1:0] acc;

   // R3: pedestal removal in signed arithmetic, wide enough for no clipping
   assign corr = $signed({{(VW-DW){1'b0}}, sample}) - $signed({{(VW-DW){1'b0}}, ped});

   always_ff @(posedge clk) begin
      if (wr) mem[idx] <= corr;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (wr)  acc <= acc + QW'(corr);
   end

   // R4: common-mode variant chosen at elaboration
   generate
      if (CM_MODE != 0) begin : g_cm_mean
         logic signed [QW-1:0] shifted;
         assign shifted = acc >>> LOG2N;
         assign mean    = shifted[VW-1:0];
      end else begin : g_cm_off
         assign mean = '0;
      end
   endgenerate

   assign rd_val = mem[idx] - mean;
endmodule

// File: rtl/sfhe_cluster.sv
module sfhe_cluster #(
   parameter int NSTRIP = 128,
   parameter int DW     = 10,
   localparam int LOG2N = $clog2(NSTRIP),
   localparam int VW    = DW + 3,
   localparam int QW    = VW + LOG2N
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic                 last,
   input  logic [LOG2N-1:0]     idx,
   input  logic signed [VW-1:0] val,
   input  logic [DW-1:0]        thr,
   output logic                 rec_valid,
   output logic [LOG2N-1:0]     rec_first,
   output logic [LOG2N:0]       rec_size,
   output logic signed [QW-1:0] rec_charge
);
   logic                 in_clu;
   logic [LOG2N-1:0]     start_q;
   logic [LOG2N:0]       cnt_q;
   logic signed [QW-1:0] sum_q;
   logic                 hit;
   logic [LOG2N-1:0]     n_start;
   logic [LOG2N:0]       n_cnt;
   logic signed [QW-1:0] n_sum;

   // R5: strict comparison against the unsigned threshold
   assign hit     = val > $signed({{(VW-DW){1'b0}}, thr});
   assign n_start = in_clu ? start_q : idx;
   assign n_cnt   = in_clu ? cnt_q + 1'b1 : (LOG2N+1)'(1);
   assign n_sum   = in_clu ? sum_q + QW'(val) : QW'(val);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_clu     <= 1'b0;
         start_q    <= '0;
         cnt_q      <= '0;
         sum_q      <= '0;
         rec_valid  <= 1'b0;
         rec_first  <= '0;
         rec_size   <= '0;
         rec_charge <= '0;
      end else begin
         rec_valid <= 1'b0;
         if (en && hit) begin
            start_q <= n_start;
            cnt_q   <= n_cnt;
            sum_q   <= n_sum;
            in_clu  <= !last;
            if (last) begin
               rec_valid  <= 1'b1;
               rec_first  <= n_start;
               rec_size   <= n_cnt;
               rec_charge <= n_sum;
            end
         end else if (en && in_clu) begin
            rec_valid  <= 1'b1;
            rec_first  <= start_q;
            rec_size   <= cnt_q;
            rec_charge <= sum_q;
            in_clu     <= 1'b0;
         end
      end
   end

   // R6: a record is non-empty and lies inside the frame
   assert_rec_bounds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> (rec_size != 0) && (int'(rec_first) + int'(rec_size) <= NSTRIP));
   // R5: every strip of a record exceeded the threshold
   assert_rec_charge_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |-> int'(rec_charge) >= int'(rec_size) * (int'(thr) + 1));
   // R6: back-to-back records only when the second closes at the last strip
   assert_rec_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rec_valid |=> (!rec_valid || int'(rec_first) + int'(rec_size) == NSTRIP));
endmodule

// File: rtl/strip_hit_extractor.sv
module strip_hit_extractor
   import sfhe_pkg::*;
#(
   parameter int NSTRIP  = 128,
   parameter int DW      = 10,
   parameter int CM_MODE = 1,
   parameter int THR_RST = 32,
   parameter int HDR_RST = 'h3A5,
   localparam int LOG2N  = $clog2(NSTRIP),
   localparam int AW     = $clog2(NSTRIP + 2),
   localparam int VW     = DW + 3,
   localparam int QW     = VW + LOG2N
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 in_valid,
   input  logic [DW-1:0]        in_data,
   input  logic                 cfg_we,
   input  logic [AW-1:0]        cfg_addr,
   input  logic [DW-1:0]        cfg_data,
   output logic                 clu_valid,
   output logic [LOG2N-1:0]     clu_first,
   output logic [LOG2N:0]       clu_size,
   output logic signed [QW-1:0] clu_charge,
   output logic                 frame_end,
   output logic                 sync_err
);
   generate
      if ((1 << LOG2N) != NSTRIP) begin : g_bad_nstrip
         $error("NSTRIP must be a power of two");
      end
      if (DW < 4 || DW > 16) begin : g_bad_dw
         $error("DW must lie between 4 and 16");
      end
   endgenerate

   sfhe_state_e          st;
   logic [LOG2N-1:0]     idx;
   logic                 idle;
   logic                 hdr_ok;
   logic                 last_idx;
   logic [DW-1:0]        ped;
   logic [DW-1:0]        thr;
   logic [DW-1:0]        hdr_pat;
   logic signed [VW-1:0] rd_val;

   assign idle     = (st == ST_HDR);
   assign hdr_ok   = in_data == hdr_pat;
   assign last_idx = idx == LOG2N'(NSTRIP - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_HDR;
         idx       <= '0;
         frame_end <= 1'b0;
         sync_err  <= 1'b0;
      end else begin
         frame_end <= 1'b0;
         sync_err  <= 1'b0;
         unique case (st)
            ST_HDR: if (in_valid) begin
               if (hdr_ok) begin
                  st  <= ST_SMP;
                  idx <= '0;
               end else begin
                  sync_err <= 1'b1;
               end
            end
            ST_SMP: if (in_valid) begin
               idx <= idx + 1'b1;
               if (last_idx) st <= ST_SCAN;
            end
            ST_SCAN: begin
               idx <= idx + 1'b1;
               if (last_idx) st <= ST_DONE;
            end
            ST_DONE: begin
               frame_end <= 1'b1;
               st        <= ST_HDR;
            end
         endcase
      end
   end

   sfhe_cfg_store #(.NSTRIP(NSTRIP), .DW(DW), .THR_RST(THR_RST), .HDR_RST(HDR_RST)) u_cfg (
      .clk(clk), .rst_n(rst_n), .idle(idle), .wr_req(cfg_we), .wr_addr(cfg_addr),
      .wr_data(cfg_data), .rd_idx(idx), .ped(ped), .thr(thr), .hdr_pat(hdr_pat)
   );

   sfhe_frame_buf #(.NSTRIP(NSTRIP), .DW(DW), .CM_MODE(CM_MODE)) u_buf (
      .clk(clk), .rst_n(rst_n), .clr(idle && in_valid && hdr_ok),
      .wr(st == ST_SMP && in_valid), .idx(idx), .sample(in_data), .ped(ped),
      .rd_val(rd_val)
   );

   sfhe_cluster #(.NSTRIP(NSTRIP), .DW(DW)) u_clu (
      .clk(clk), .rst_n(rst_n), .en(st == ST_SCAN), .last(last_idx), .idx(idx),
      .val(rd_val), .thr(thr), .rec_valid(clu_valid), .rec_first(clu_first),
      .rec_size(clu_size), .rec_charge(clu_charge)
   );

   // R2: a rejected header always follows a valid word
   assert_sync_after_word_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sync_err |-> $past(in_valid));
   // R7: frame end never coincides with a record
   assert_end_no_record_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |-> !clu_valid);
   // R7: frame end lasts one cycle
   assert_end_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
      frame_end |=> !frame_end);
endmodule

// File: tb/sim_strip_hit_extractor.sv
module sim_strip_hit_extractor;
   localparam int CLK_P  = 10;
   localparam int N      = 128;
   localparam int DW     = 10;
   localparam int AW     = $clog2(N + 2);
   localparam int QW     = DW + 3 + $clog2(N);
   localparam int HDR    = 'h3A5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic in_valid = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic cfg_we = 1'b0;
   logic [AW-1:0] cfg_addr = '0;
   logic [DW-1:0] cfg_data = '0;
   logic clu_valid;
   logic [6:0] clu_first;
   logic [7:0] clu_size;
   logic signed [QW-1:0] clu_charge;
   logic frame_end, sync_err;

   strip_hit_extractor u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data),
      .clu_valid(clu_valid), .clu_first(clu_first), .clu_size(clu_size),
      .clu_charge(clu_charge), .frame_end(frame_end), .sync_err(sync_err)
   );

   always #(CLK_P/2) clk = ~clk;

   int checks = 0, errors = 0, cyc = 0;
   int ped_m [N];
   int thr_m;
   int smp [N];
   int g_first [64], g_size [64], g_charge [64];
   int g_n = 0, fe_n = 0, se_n = 0;
   int e_first [64], e_size [64], e_charge [64];
   int e_n;

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         errors++;
         $display("FAIL watchdog (all requirements) cycles %0d expected below 150000", cyc);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   always @(negedge clk) if (rst_n) begin
      if (clu_valid && g_n < 64) begin
         g_first[g_n] = int'(clu_first);
         g_size[g_n] = int'(clu_size);
         g_charge[g_n] = int'(clu_charge);
         g_n++;
      end
      if (frame_end) fe_n++;
      if (sync_err) se_n++;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic cfg_write(input int addr, input int data);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = AW'(addr); cfg_data = DW'(data);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic load_peds();
      for (int i = 0; i < N; i++) cfg_write(i, ped_m[i]);
   endtask

   task automatic send_frame(input int hdr);
      @(negedge clk);
      in_valid = 1'b1; in_data = DW'(hdr);
      for (int i = 0; i < N; i++) begin
         @(negedge clk);
         in_data = DW'(smp[i]);
      end
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_end(input int fe0, input string req);
      int k = 0;
      while (!frame_end && k < 400) begin
         @(negedge clk);
         k++;
      end
      @(negedge clk);
      check(fe_n == fe0 + 1, req, fe_n - fe0, 1);
      check(!frame_end, req, int'(frame_end), 0);
   endtask

   task automatic build_expect();
      int c [N];
      int sum = 0, mean, v, run = 0, first = 0, chg = 0;
      for (int i = 0; i < N; i++) begin
         c[i] = smp[i] - ped_m[i];
         sum += c[i];
      end
      mean = sum >>> 7;
      e_n = 0;
      for (int i = 0; i < N; i++) begin
         v = c[i] - mean;
         if (v > thr_m) begin
            if (run == 0) begin first = i; chg = 0; end
            run++; chg += v;
            if (i == N - 1) begin
               e_first[e_n] = first; e_size[e_n] = run; e_charge[e_n] = chg; e_n++; run = 0;
            end
         end else if (run > 0) begin
            e_first[e_n] = first; e_size[e_n] = run; e_charge[e_n] = chg; e_n++; run = 0;
         end
      end
   endtask

   task automatic compare(input string req);
      build_expect();
      check(g_n == e_n, {req, " record count"}, g_n, e_n);
      for (int k = 0; k < g_n && k < e_n; k++) begin
         check(g_first[k] == e_first[k], {req, " first"}, g_first[k], e_first[k]);
         check(g_size[k] == e_size[k], {req, " size"}, g_size[k], e_size[k]);
         check(g_charge[k] == e_charge[k], {req, " charge"}, g_charge[k], e_charge[k]);
      end
   endtask

   task automatic run_frame(input string req);
      int fe0 = fe_n;
      g_n = 0;
      send_frame(HDR);
      wait_end(fe0, "R7 frame end");
      compare(req);
   endtask

   task automatic t_reset();
      @(negedge clk);
      check(!clu_valid && !frame_end && !sync_err, "R10 reset outputs",
            int'({clu_valid, frame_end, sync_err}), 0);
   endtask

   task automatic t_basic();
      for (int i = 0; i < N; i++) ped_m[i] = (i * 3) % 400;
      load_peds();
      thr_m = 20; cfg_write(N, thr_m);
      cfg_write(N + 1, HDR);
      for (int i = 0; i < N; i++) smp[i] = ped_m[i];
      smp[10] += 200; smp[11] += 150; smp[12] += 90;
      run_frame("R1 R3 R6 single cluster");
      check(g_n == 1 && g_first[0] == 10 && g_size[0] == 3, "R6 explicit record",
            g_first[0], 10);
   endtask

   task automatic t_edges();
      for (int i = 0; i < N; i++) smp[i] = ped_m[i];
      smp[0] += 300; smp[1] += 300; smp[124] += 300; smp[125] += 300; smp[127] += 300;
      run_frame("R6 edge clusters");
      check(g_n == 3 && g_first[2] == 127 && g_size[2] == 1, "R6 last strip run",
            g_first[2], 127);
   endtask

   task automatic t_threshold();
      for (int i = 0; i < N; i++) smp[i] = ped_m[i];
      smp[50] += 20; smp[60] += 21;
      run_frame("R5 threshold equality");
      check(g_n == 1 && g_first[0] == 60 && g_charge[0] == 21, "R5 only above threshold",
            g_charge[0], 21);
   endtask

   task automatic t_common_mode();
      for (int i = 0; i < N; i++) smp[i] = ped_m[i] + 40;
      smp[30] += 60; smp[31] += 60;
      run_frame("R4 positive common mode");
      check(g_n == 1 && g_size[0] == 2 && g_charge[0] == 120, "R4 positive offset removed",
            g_charge[0], 120);
      for (int i = 0; i < N; i++) begin ped_m[i] = 100; smp[i] = 50; end
      load_peds();
      smp[90] = 100;
      run_frame("R4 negative common mode");
      check(g_n == 1 && g_first[0] == 90 && g_charge[0] == 50, "R4 floor rounding",
            g_charge[0], 50);
   endtask

   task automatic t_sync();
      int se0 = se_n, fe0 = fe_n;
      @(negedge clk); in_valid = 1'b1; in_data = DW'(HDR ^ 1);
      @(negedge clk); in_valid = 1'b0;
      @(negedge clk); @(negedge clk);
      check(se_n == se0 + 1, "R2 single bad header", se_n - se0, 1);
      for (int i = 0; i < N; i++) smp[i] = 100 + (i % 7);
      send_frame(HDR ^ 'h10);
      repeat (4) @(negedge clk);
      check(se_n == se0 + 1 + N + 1, "R2 missing header flags all", se_n - se0, N + 2);
      check(fe_n == fe0, "R2 no frame without header", fe_n - fe0, 0);
      smp[70] = 400;
      run_frame("R2 recovery after bad header");
   endtask

   task automatic t_busy();
      int fe0 = fe_n, se0;
      for (int i = 0; i < N; i++) smp[i] = ped_m[i] + (i % 5);
      smp[20] += 200; smp[21] += 80;
      g_n = 0;
      send_frame(HDR);
      se0 = se_n;
      in_valid = 1'b1; in_data = DW'(HDR);
      cfg_we = 1'b1; cfg_addr = AW'(20); cfg_data = DW'(999);
      @(negedge clk);
      cfg_addr = AW'(N); cfg_data = '0;
      @(negedge clk);
      in_valid = 1'b0; cfg_we = 1'b0;
      wait_end(fe0, "R9 frame end");
      compare("R9 frame under busy stimulus");
      check(se_n == se0, "R9 no sync error while busy", se_n - se0, 0);
      run_frame("R8 config unchanged after busy write");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      check(!clu_valid && !frame_end && !sync_err, "R10 outputs in reset",
            int'({clu_valid, frame_end, sync_err}), 0);
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_edges();
      t_threshold();
      t_common_mode();
      t_sync();
      t_busy();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule